// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the data accesses of a load/store pipeline and raises a break flag when an access falls inside a watched region. It holds a parameterised number of watchpoints (two by default). Each watchpoint has an address register and a control register. The control register carries a load enable, a store enable and a low-order compare mask. Software programs these registers through a simple write port. From then on, every valid access presented on the access port is compared against all armed watchpoints in the same cycle, so the pipeline can stop the access before it is performed.

The compare mask selects a naturally aligned region whose size is a power of two bytes. A mask field that would describe a broken region is repaired when it is written. The repair keeps the run of ones that starts at the top of the field and clears every bit below the first zero. Both the normalised mask and the aligned base are worked out at write time. This keeps the per-access path down to one AND and one equality compare per watchpoint.

Each watchpoint is a four-state machine: `WP_OFF` (disarmed), `WP_LD` (loads only), `WP_ST` (stores only) and `WP_LDST` (both). The only transitions are control-register writes to that watchpoint. The written enable pair picks the next state from any state: neither enable goes to `WP_OFF`, load only goes to `WP_LD`, store only goes to `WP_ST`, and both go to `WP_LDST`. Without such a write, the state holds. Reset places every machine in `WP_OFF`.

Top module: `wp_unit`

## Requirements
- R1: After reset every watchpoint is in `WP_OFF`, `brk` is 0 and `brk_idx` is 0 for any access.
- R2: Control bit 6 is the load enable and bit 7 is the store enable. A watchpoint with only bit 7 set hits only writes (`acc_write`=1). With only bit 6 set it hits only reads. With both set it hits both. With neither set it never hits.
- R3: Control bits [5:0] form the compare mask, where 1 means the address bit is compared. All address bits above bit 5 are always compared. An access hits when `(acc_addr & M) == (wp_addr & M)`, so the region is aligned and spans `~M + 1` bytes.
- R4: On a control write, a mask field that is not a run of ones from bit 5 downward is replaced by its leading ones up to the first zero. For example, 6'b101111 acts as 6'b100000 and 6'b011111 acts as 6'b000000.
- R5: `brk` is a combinational function of the access inputs in the cycle the access is presented, and is 0 whenever `acc_valid` is 0.
- R6: When several watchpoints hit the same access, `brk_idx` reports the lowest index.
- R7: A configuration write takes effect at the clock edge that samples it. An access in the same cycle as the write is compared against the previous setting.
- R8: A control write re-derives the region from the stored address and the new mask. A control write with both enables clear disarms the watchpoint.
- R9: An address written while a watchpoint is disarmed is retained and used once the watchpoint is armed.
- R10: `brk_idx` is 0 whenever `brk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctrl | input | 1 | 1 selects the control register, 0 the address register |
| cfg_idx | input | IDXW | Watchpoint index to write |
| cfg_wdata | input | ADDR_W | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | ADDR_W | Access byte address |
| brk | output | 1 | Access hits at least one armed watchpoint |
| brk_idx | output | IDXW | Lowest index among the hitting watchpoints |

## Verification
The hardest case to reach from the ports is an access presented in the same cycle as a configuration write that moves the watched region. The bench drives both on one falling edge and samples `brk` before the next rising edge to see the old region. It then samples again after the edge to see the new one. Overlapping hits are built by giving the two watchpoints regions of different sizes that share one address. Disarming the lower index afterwards shows the report moving to the higher index.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {
        WP_OFF  = 2'b00,
        WP_LD   = 2'b01,
        WP_ST   = 2'b10,
        WP_LDST = 2'b11
    } wp_state_e;
endpackage

// File: rtl/wp_mask_norm.sv
module wp_mask_norm #(
    parameter int MASK_W = 6
) (
    input  logic [MASK_W-1:0] raw,
    output logic [MASK_W-1:0] fixed
);
    // keep the run of ones starting at the top bit; clear all below first zero
    always_comb begin
        logic keep;
        keep  = 1'b1;
        fixed = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            keep     = keep & raw[i];
            fixed[i] = keep;
        end
    end
endmodule

// File: rtl/wp_slot.sv
module wp_slot
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_en,
    input  logic              wr_ctrl_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit
);
    localparam int LD_BIT = MASK_W;
    localparam int ST_BIT = MASK_W + 1;
    localparam int HI_W   = ADDR_W - MASK_W;

    wp_state_e         state_q, state_d;
    logic [ADDR_W-1:0] raw_addr_q;
    logic [ADDR_W-1:0] base_q;
    logic [MASK_W-1:0] field_q;
    logic [MASK_W-1:0] field_new;
    logic [ADDR_W-1:0] mask_full, mask_new;
    logic              ld_arm, st_arm;

    wp_mask_norm #(.MASK_W(MASK_W)) u_norm (
        .raw   (wr_data[MASK_W-1:0]),
        .fixed (field_new)
    );

    assign mask_full = {{HI_W{1'b1}}, field_q};
    assign mask_new  = {{HI_W{1'b1}}, field_new};

    // next-state: only a control write moves the machine
    always_comb begin
        state_d = state_q;
        if (wr_ctrl_en) begin
            unique case ({wr_data[ST_BIT], wr_data[LD_BIT]})
                2'b00: state_d = WP_OFF;
                2'b01: state_d = WP_LD;
                2'b10: state_d = WP_ST;
                2'b11: state_d = WP_LDST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WP_OFF;
        else        state_q <= state_d;
    end

    // address, mask and aligned base are settled at write time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_addr_q <= '0;
            field_q    <= '1;
            base_q     <= '0;
        end else if (wr_ctrl_en) begin
            field_q <= field_new;
            base_q  <= raw_addr_q & mask_new;
        end else if (wr_addr_en) begin
            raw_addr_q <= wr_data;
            base_q     <= wr_data & mask_full;
        end
    end

    // outputs decoded from the state
    always_comb begin
        unique case (state_q)
            WP_OFF:  begin ld_arm = 1'b0; st_arm = 1'b0; end
            WP_LD:   begin ld_arm = 1'b1; st_arm = 1'b0; end
            WP_ST:   begin ld_arm = 1'b0; st_arm = 1'b1; end
            WP_LDST: begin ld_arm = 1'b1; st_arm = 1'b1; end
        endcase
    end

    assign hit = acc_valid && (acc_write ? st_arm : ld_arm)
                 && ((acc_addr & mask_full) == base_q);

    logic [ADDR_W-1:0] inv_m, inv_p1;
    assign inv_m  = ~mask_full;
    assign inv_p1 = inv_m + {{(ADDR_W-1){1'b0}}, 1'b1};

    p_mask_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_p1 & inv_m) == '0);
    p_base_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (base_q & inv_m) == '0);
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WP_OFF) |-> !hit);
    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_en && !wr_data[LD_BIT] && !wr_data[ST_BIT]) |=> (state_q == WP_OFF));
endmodule

// File: rtl/wp_prio.sv
module wp_prio #(
    parameter int N    = 2,
    parameter int IDXW = 1
) (
    input  logic [N-1:0]    hits,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDXW'(i);
        end
    end
    assign any = |hits;
endmodule

// File: rtl/wp_unit.sv
module wp_unit #(
    parameter int NUM_WP = 2,
    parameter int ADDR_W = 32,
    parameter int MASK_W = 6,
    localparam int IDXW  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ctrl,
    input  logic [IDXW-1:0]   cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              brk,
    output logic [IDXW-1:0]   brk_idx
);
    logic [NUM_WP-1:0] hits;

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        logic sel;
        assign sel = cfg_we && (cfg_idx == IDXW'(g));
        wp_slot #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr_en (sel && !cfg_ctrl),
            .wr_ctrl_en (sel && cfg_ctrl),
            .wr_data    (cfg_wdata),
            .acc_valid  (acc_valid),
            .acc_write  (acc_write),
            .acc_addr   (acc_addr),
            .hit        (hits[g])
        );
    end

    wp_prio #(.N(NUM_WP), .IDXW(IDXW)) u_prio (
        .hits (hits),
        .any  (brk),
        .idx  (brk_idx)
    );

    p_brk_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> acc_valid);
    p_idx_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> (hits[brk_idx] && ((hits & ~({NUM_WP{1'b1}} << brk_idx)) == '0)));
    p_idle_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !brk |-> (brk_idx == '0));
endmodule

// File: tb/tb_wp_unit.sv
module tb_wp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_ctrl = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        brk;
    logic [0:0]  brk_idx;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wp_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_addr(acc_addr), .brk(brk), .brk_idx(brk_idx)
    );

    function automatic logic [31:0] ctl(input bit ld, input bit st, input logic [5:0] m);
        return {24'b0, st, ld, m};
    endfunction

    task automatic wr(input int idx, input bit is_ctrl, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctrl = is_ctrl; cfg_idx = 1'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string req, input logic [31:0] a, input bit w,
                         input bit v, input bit eb, input int ei);
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_addr = a;
        #1;
        total++;
        if (brk !== eb || int'(brk_idx) != ei) begin
            bad++;
            $display("FAIL %s addr=%h wr=%0d: brk=%0b idx=%0d expected brk=%0b idx=%0d",
                     req, a, w, brk, brk_idx, eb, ei);
        end
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();   // R1 R10
        probe("R1", 32'h0, 1'b0, 1'b1, 1'b0, 0);
        probe("R1", 32'h0, 1'b1, 1'b1, 1'b0, 0);
        probe("R10", 32'h3f, 1'b1, 1'b1, 1'b0, 0);
    endtask

    task automatic t_enables(); // R2
        wr(0, 0, 32'h1000);
        wr(0, 1, ctl(0, 1, 6'h3f));
        probe("R2", 32'h1000, 1'b1, 1'b1, 1'b1, 0);
        probe("R2", 32'h1000, 1'b0, 1'b1, 1'b0, 0);
        wr(0, 1, ctl(1, 0, 6'h3f));
        probe("R2", 32'h1000, 1'b0, 1'b1, 1'b1, 0);
        probe("R2", 32'h1000, 1'b1, 1'b1, 1'b0, 0);
        wr(0, 1, ctl(1, 1, 6'h3f));
        probe("R2", 32'h1000, 1'b0, 1'b1, 1'b1, 0);
        probe("R2", 32'h1000, 1'b1, 1'b1, 1'b1, 0);
        probe("R3", 32'h1001, 1'b1, 1'b1, 1'b0, 0);
    endtask

    task automatic t_region();  // R3
        wr(0, 0, 32'h2005);
        wr(0, 1, ctl(1, 1, 6'b111000));
        probe("R3", 32'h2000, 1'b0, 1'b1, 1'b1, 0);
        probe("R3", 32'h2007, 1'b1, 1'b1, 1'b1, 0);
        probe("R3", 32'h2008, 1'b0, 1'b1, 1'b0, 0);
        probe("R3", 32'h1fff, 1'b0, 1'b1, 1'b0, 0);
        wr(0, 0, 32'h3000);
        wr(0, 1, ctl(1, 1, 6'b000000));
        probe("R3", 32'h303f, 1'b0, 1'b1, 1'b1, 0);
        probe("R3", 32'h3040, 1'b0, 1'b1, 1'b0, 0);
        probe("R3", 32'h13000, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_repair();  // R4
        wr(0, 0, 32'h4000);
        wr(0, 1, ctl(1, 1, 6'b101111));
        probe("R4", 32'h401f, 1'b0, 1'b1, 1'b1, 0);
        probe("R4", 32'h4010, 1'b0, 1'b1, 1'b1, 0);
        probe("R4", 32'h4020, 1'b0, 1'b1, 1'b0, 0);
        wr(0, 1, ctl(1, 1, 6'b011111));
        probe("R4", 32'h403f, 1'b0, 1'b1, 1'b1, 0);
        probe("R4", 32'h4040, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_valid();   // R5
        probe("R5", 32'h4000, 1'b0, 1'b0, 1'b0, 0);
        probe("R5", 32'h4000, 1'b0, 1'b1, 1'b1, 0);
    endtask

    task automatic t_prio();    // R6
        wr(0, 0, 32'h5000);
        wr(0, 1, ctl(1, 1, 6'b000000));
        wr(1, 0, 32'h5008);
        wr(1, 1, ctl(1, 1, 6'b111000));
        probe("R6", 32'h500c, 1'b0, 1'b1, 1'b1, 0);
        probe("R6", 32'h5001, 1'b0, 1'b1, 1'b1, 0);
        wr(0, 1, ctl(0, 0, 6'b000000));
        probe("R6", 32'h500c, 1'b0, 1'b1, 1'b1, 1);
        probe("R6", 32'h5001, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_same_cycle(); // R7
        // wp1 currently watches 0x5008..0x500f; move it while accessing the old region
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctrl = 1'b0; cfg_idx = 1'b1; cfg_wdata = 32'h7000;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h5008;
        #1;
        total++;
        if (brk !== 1'b1 || brk_idx !== 1'b1) begin
            bad++;
            $display("FAIL R7 same-cycle brk=%0b idx=%0d expected brk=1 idx=1", brk, brk_idx);
        end
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        probe("R7", 32'h5008, 1'b1, 1'b1, 1'b0, 0);
        probe("R7", 32'h7007, 1'b1, 1'b1, 1'b1, 1);
    endtask

    task automatic t_ctrl_rederive(); // R8
        wr(1, 0, 32'h6013);
        wr(1, 1, ctl(1, 1, 6'h3f));
        probe("R8", 32'h6013, 1'b0, 1'b1, 1'b1, 1);
        probe("R8", 32'h601f, 1'b0, 1'b1, 1'b0, 0);
        wr(1, 1, ctl(1, 1, 6'b110000));
        probe("R8", 32'h601f, 1'b0, 1'b1, 1'b1, 1);
        probe("R8", 32'h6010, 1'b0, 1'b1, 1'b1, 1);
        probe("R8", 32'h600f, 1'b0, 1'b1, 1'b0, 0);
        wr(1, 1, ctl(0, 0, 6'b110000));
        probe("R8", 32'h6013, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic t_disarmed_addr(); // R9
        wr(0, 0, 32'h8800);
        probe("R9", 32'h8800, 1'b0, 1'b1, 1'b0, 0);
        wr(0, 1, ctl(0, 1, 6'h3f));
        probe("R9", 32'h8800, 1'b1, 1'b1, 1'b1, 0);
        probe("R10", 32'h8801, 1'b1, 1'b1, 1'b0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enables();
        t_region();
        t_repair();
        t_valid();
        t_prio();
        t_same_cycle();
        t_ctrl_rederive();
        t_disarmed_addr();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule